// File: doc/BRIEF.md
# Banked UART Host Register Bank

This block is the processor-facing register bank of a 16550-compatible serial port. A host reaches it through a 3-bit address, separate read and write strobes, an 8-bit data bus and two active-low chip selects. The port responds when either chip select is low. The block keeps the line control, modem control, interrupt enable and scratch registers and the 16-bit baud divisor. Received and transmitted data words pass to and from the serial datapath through one-cycle strobes. Interrupt identification, line status and modem status values are produced elsewhere and arrive as inputs.

Bit 7 of the line control register is a bank-select bit. When it is set, addresses 0 and 1 reach the low and high bytes of the divisor instead of the data and interrupt-enable registers. Address 2 has a split meaning. A read returns the interrupt identification value. A write sends a FIFO control byte out as a strobe, and that byte is never stored for read-back.

A register update, a read-data update and every strobe all appear on the outputs in the cycle that follows the access.

Top module: `uart_regbank`

## Requirements
- R1: After reset, read data, line control, modem control, interrupt enable, scratch and divisor are all zero and no strobe is active. The bank-select bit is therefore clear.
- R2: In a cycle where both chip selects are high, read and write strobes have no effect. No register changes, read data holds and no strobe fires.
- R3: With the bank bit (line control bit 7) at 0, a read of address 0 returns the receive word and pulses rx_pop for exactly one cycle.
- R4: With the bank bit at 0, a write to address 0 pulses tx_push for one cycle, and tx_word carries the written byte.
- R5: With the bank bit at 0, address 1 reads and writes the interrupt enable register.
- R6: With the bank bit at 1, address 0 reads and writes the divisor low byte and address 1 reads and writes the divisor high byte. The divisor output is {high, low}. Neither access produces rx_pop or tx_push.
- R7: Address 2 ignores the bank bit. A read returns irq_id. A write pulses fifo_ctl_stb for one cycle, and fifo_ctl_byte carries the written byte. A later read of address 2 still returns irq_id.
- R8: Addresses 3 to 7 ignore the bank bit and map to line control (3), modem control (4), line status (5, read only), modem status (6, read only) and scratch (7). A write to address 5 or 6 changes nothing.
- R9: Line control bits 1:0 give the word length: 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8. A receive-buffer read returns the word right-justified, with the unused upper bits forced to 0.
- R10: Each chip select works on its own. Either one low, or both low, enables the access.
- R11: Read data is registered. It shows the selected value in the cycle after the read and holds it until the next enabled read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b_n | input | 1 | Chip select B, active low |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_word | input | 8 | Receive word offered by the receive path |
| rx_pop | output | 1 | One-cycle pop of the receive word |
| tx_word | output | 8 | Byte handed to the transmit path |
| tx_push | output | 1 | One-cycle push strobe to the transmit path |
| irq_id | input | 8 | Interrupt identification value |
| line_stat | input | 8 | Line status value |
| modem_stat | input | 8 | Modem status value |
| fifo_ctl_stb | output | 1 | One-cycle FIFO control write strobe |
| fifo_ctl_byte | output | 8 | FIFO control byte |
| line_ctl | output | 8 | Line control register |
| modem_ctl | output | 8 | Modem control register |
| irq_en | output | 8 | Interrupt enable register |
| divisor | output | 16 | Baud divisor {high, low} |

## Verification
A wrong bank bit shows up as address 0 or 1 going to the wrong register. The result is a missing or spurious rx_pop or tx_push in the very next cycle, or a divisor output that moves when it should not. A wrong decode of the split address 2 shows up as a stored FIFO control byte read back where irq_id is expected. A bad word-length mask shows up as nonzero upper bits on the next receive-buffer read. Every fault shows up one cycle after the access, because every output is registered exactly once.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam int DW   = 8;
    localparam int AW   = 3;
    localparam int DIVW = 2 * DW;
    localparam int BANK_BIT = DW - 1;

    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_DATA,
        TGT_IEN,
        TGT_DIV_LO,
        TGT_DIV_HI,
        TGT_ID_FCTL,
        TGT_LCTL,
        TGT_MCTL,
        TGT_LSTAT,
        TGT_MSTAT,
        TGT_SCRATCH
    } tgt_e;

    typedef struct packed {
        logic [DW-1:0] lctl;
        logic [DW-1:0] mctl;
        logic [DW-1:0] ien;
        logic [DW-1:0] scratch;
        logic [DW-1:0] div_lo;
        logic [DW-1:0] div_hi;
        logic [DW-1:0] rdata;
        logic          rx_pop;
        logic          tx_push;
        logic [DW-1:0] tx_byte;
        logic          fctl_stb;
        logic [DW-1:0] fctl_byte;
    } bank_t;

    function automatic logic [DW-1:0] word_mask(input logic [DW-1:0] w,
                                                input logic [1:0]    wlen);
        logic [DW-1:0] m;
        case (wlen)
            2'd0:    m = 8'h1F;
            2'd1:    m = 8'h3F;
            2'd2:    m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return w & m;
    endfunction

endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
    import uart_regbank_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          bank,
    input  logic          enable,
    output tgt_e          tgt
);
    always_comb begin
        tgt = TGT_NONE;
        if (enable) begin
            case (addr)
                3'd0:    tgt = bank ? TGT_DIV_LO : TGT_DATA;
                3'd1:    tgt = bank ? TGT_DIV_HI : TGT_IEN;
                3'd2:    tgt = TGT_ID_FCTL;
                3'd3:    tgt = TGT_LCTL;
                3'd4:    tgt = TGT_MCTL;
                3'd5:    tgt = TGT_LSTAT;
                3'd6:    tgt = TGT_MSTAT;
                default: tgt = TGT_SCRATCH;
            endcase
        end
    end
endmodule

// File: rtl/uart_regbank_rdmux.sv
module uart_regbank_rdmux
    import uart_regbank_pkg::*;
(
    input  tgt_e          tgt,
    input  bank_t         cur,
    input  logic [DW-1:0] rx_word,
    input  logic [DW-1:0] irq_id,
    input  logic [DW-1:0] line_stat,
    input  logic [DW-1:0] modem_stat,
    output logic [DW-1:0] value
);
    always_comb begin
        case (tgt)
            TGT_DATA:    value = word_mask(rx_word, cur.lctl[1:0]);
            TGT_IEN:     value = cur.ien;
            TGT_DIV_LO:  value = cur.div_lo;
            TGT_DIV_HI:  value = cur.div_hi;
            TGT_ID_FCTL: value = irq_id;
            TGT_LCTL:    value = cur.lctl;
            TGT_MCTL:    value = cur.mctl;
            TGT_LSTAT:   value = line_stat;
            TGT_MSTAT:   value = modem_stat;
            TGT_SCRATCH: value = cur.scratch;
            default:     value = '0;
        endcase
    end
endmodule

// File: rtl/uart_regbank_regs.sv
module uart_regbank_regs
    import uart_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  tgt_e          tgt,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rd_value,
    output bank_t         bank_q
);
    bank_t bank_d;

    always_comb begin
        bank_d          = bank_q;
        bank_d.rx_pop   = 1'b0;
        bank_d.tx_push  = 1'b0;
        bank_d.fctl_stb = 1'b0;
        if (wr_en) begin
            case (tgt)
                TGT_DATA: begin
                    bank_d.tx_push = 1'b1;
                    bank_d.tx_byte = wdata;
                end
                TGT_IEN:     bank_d.ien     = wdata;
                TGT_DIV_LO:  bank_d.div_lo  = wdata;
                TGT_DIV_HI:  bank_d.div_hi  = wdata;
                TGT_ID_FCTL: begin
                    bank_d.fctl_stb  = 1'b1;
                    bank_d.fctl_byte = wdata;
                end
                TGT_LCTL:    bank_d.lctl    = wdata;
                TGT_MCTL:    bank_d.mctl    = wdata;
                TGT_SCRATCH: bank_d.scratch = wdata;
                default: ;
            endcase
        end
        if (rd_en && tgt != TGT_NONE) begin
            bank_d.rdata = rd_value;
            if (tgt == TGT_DATA) begin
                bank_d.rx_pop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_a_n,
    input  logic            sel_b_n,
    input  logic [AW-1:0]   addr,
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [DW-1:0]   rx_word,
    output logic            rx_pop,
    output logic [DW-1:0]   tx_word,
    output logic            tx_push,
    input  logic [DW-1:0]   irq_id,
    input  logic [DW-1:0]   line_stat,
    input  logic [DW-1:0]   modem_stat,
    output logic            fifo_ctl_stb,
    output logic [DW-1:0]   fifo_ctl_byte,
    output logic [DW-1:0]   line_ctl,
    output logic [DW-1:0]   modem_ctl,
    output logic [DW-1:0]   irq_en,
    output logic [DIVW-1:0] divisor
);
    logic          enable;
    tgt_e          tgt;
    bank_t         bank_q;
    logic [DW-1:0] rd_value;

    assign enable = !sel_a_n || !sel_b_n;

    uart_regbank_decode u_decode (
        .addr   (addr),
        .bank   (bank_q.lctl[BANK_BIT]),
        .enable (enable),
        .tgt    (tgt)
    );

    uart_regbank_rdmux u_rdmux (
        .tgt        (tgt),
        .cur        (bank_q),
        .rx_word    (rx_word),
        .irq_id     (irq_id),
        .line_stat  (line_stat),
        .modem_stat (modem_stat),
        .value      (rd_value)
    );

    uart_regbank_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt      (tgt),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .rd_value (rd_value),
        .bank_q   (bank_q)
    );

    assign rdata         = bank_q.rdata;
    assign rx_pop        = bank_q.rx_pop;
    assign tx_word       = bank_q.tx_byte;
    assign tx_push       = bank_q.tx_push;
    assign fifo_ctl_stb  = bank_q.fctl_stb;
    assign fifo_ctl_byte = bank_q.fctl_byte;
    assign line_ctl      = bank_q.lctl;
    assign modem_ctl     = bank_q.mctl;
    assign irq_en        = bank_q.ien;
    assign divisor       = {bank_q.div_hi, bank_q.div_lo};
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk
    import uart_regbank_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            sel_a_n,
    input logic            sel_b_n,
    input logic [AW-1:0]   addr,
    input logic            rd_en,
    input logic            wr_en,
    input logic [DW-1:0]   wdata,
    input logic [DW-1:0]   rdata,
    input logic            rx_pop,
    input logic [DW-1:0]   tx_word,
    input logic            tx_push,
    input logic [DW-1:0]   line_stat,
    input logic            fifo_ctl_stb,
    input logic [DW-1:0]   fifo_ctl_byte,
    input logic [DW-1:0]   line_ctl,
    input logic [DIVW-1:0] divisor
);
    logic hit;
    assign hit = !sel_a_n || !sel_b_n;

    // R2
    no_select_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hit) |-> !rx_pop && !tx_push && !fifo_ctl_stb && $stable(rdata) && $stable(line_ctl));

    // R3
    pop_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> $past(hit && rd_en && addr == 3'd0 && !line_ctl[BANK_BIT]));

    // R4
    push_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> $past(hit && wr_en && addr == 3'd0 && !line_ctl[BANK_BIT]) && tx_word == $past(wdata));

    // R6
    divisor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(divisor) |-> $past(hit && wr_en && addr[2:1] == 2'b00 && line_ctl[BANK_BIT]));

    // R7
    fctl_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ctl_stb |-> $past(hit && wr_en && addr == 3'd2) && fifo_ctl_byte == $past(wdata));

    // R8
    lstat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit && rd_en && addr == 3'd5) |-> rdata == $past(line_stat));

    // R8
    lctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_ctl) |-> $past(hit && wr_en && addr == 3'd3));
endmodule

bind uart_regbank uart_regbank_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_a_n       (sel_a_n),
    .sel_b_n       (sel_b_n),
    .addr          (addr),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .wdata         (wdata),
    .rdata         (rdata),
    .rx_pop        (rx_pop),
    .tx_word       (tx_word),
    .tx_push       (tx_push),
    .line_stat     (line_stat),
    .fifo_ctl_stb  (fifo_ctl_stb),
    .fifo_ctl_byte (fifo_ctl_byte),
    .line_ctl      (line_ctl),
    .divisor       (divisor)
);

// File: tb/uart_regbank_test.sv
`timescale 1ns/1ps
module uart_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_a_n = 1'b1, sel_b_n = 1'b1;
    logic [2:0]  addr = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]  wdata = '0, rdata, rx_word = '0, tx_word;
    logic        rx_pop, tx_push, fifo_ctl_stb;
    logic [7:0]  irq_id = '0, line_stat = '0, modem_stat = '0;
    logic [7:0]  fifo_ctl_byte, line_ctl, modem_ctl, irq_en;
    logic [15:0] divisor;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_lctl = 0, m_mctl = 0, m_ien = 0, m_scr = 0, m_dlo = 0, m_dhi = 0, m_rd = 0;

    always #2.5 clk = ~clk;

    uart_regbank uut (
        .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
        .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .rx_word(rx_word), .rx_pop(rx_pop), .tx_word(tx_word), .tx_push(tx_push),
        .irq_id(irq_id), .line_stat(line_stat), .modem_stat(modem_stat),
        .fifo_ctl_stb(fifo_ctl_stb), .fifo_ctl_byte(fifo_ctl_byte),
        .line_ctl(line_ctl), .modem_ctl(modem_ctl), .irq_en(irq_en), .divisor(divisor)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_len(input logic [7:0] w, input logic [1:0] wl);
        return w & (8'hFF >> (3 - wl));
    endfunction

    function automatic string tag_for(input logic [2:0] a, input logic bank, input bit wr);
        if (a == 0) return bank ? "R6" : (wr ? "R4" : "R3");
        if (a == 1) return bank ? "R6" : "R5";
        if (a == 2) return "R7";
        return "R8";
    endfunction

    task automatic do_op(input bit wr, input logic [2:0] a, input logic [1:0] csm, input logic [7:0] d);
        bit hit = (csm != 2'd3);
        logic bank = m_lctl[7];
        logic [7:0] exp_rd;
        bit exp_pop = 0, exp_push = 0, exp_fs = 0;
        string tag = hit ? tag_for(a, bank, wr) : "R2";
        logic [7:0] rxw = 8'($urandom()), iid = 8'($urandom()), ls = 8'($urandom()), ms = 8'($urandom());
        rx_word = rxw; irq_id = iid; line_stat = ls; modem_stat = ms;
        sel_a_n = !(csm == 2'd0 || csm == 2'd2);
        sel_b_n = !(csm == 2'd1 || csm == 2'd2);
        addr = a; wdata = d; wr_en = wr; rd_en = !wr;
        exp_rd = m_rd;
        if (hit && !wr) begin
            case (a)
                3'd0: begin
                    exp_rd = bank ? m_dlo : mask_len(rxw, m_lctl[1:0]);
                    exp_pop = !bank;
                end
                3'd1: exp_rd = bank ? m_dhi : m_ien;
                3'd2: exp_rd = iid;
                3'd3: exp_rd = m_lctl;
                3'd4: exp_rd = m_mctl;
                3'd5: exp_rd = ls;
                3'd6: exp_rd = ms;
                default: exp_rd = m_scr;
            endcase
            m_rd = exp_rd;
        end
        if (hit && wr) begin
            case (a)
                3'd0: if (bank) m_dlo = d; else exp_push = 1;
                3'd1: if (bank) m_dhi = d; else m_ien = d;
                3'd2: exp_fs = 1;
                3'd3: m_lctl = d;
                3'd4: m_mctl = d;
                3'd7: m_scr = d;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0; sel_a_n = 1; sel_b_n = 1;
        // R11 read data registered and held
        chk(wr ? "R11" : tag, "rdata", {8'h0, rdata}, {8'h0, exp_rd});
        chk(tag, "rx_pop", {15'h0, rx_pop}, {15'h0, exp_pop});
        chk(tag, "tx_push", {15'h0, tx_push}, {15'h0, exp_push});
        if (exp_push) chk("R4", "tx_word", {8'h0, tx_word}, {8'h0, d});
        chk(tag, "fifo_ctl_stb", {15'h0, fifo_ctl_stb}, {15'h0, exp_fs});
        if (exp_fs) chk("R7", "fifo_ctl_byte", {8'h0, fifo_ctl_byte}, {8'h0, d});
        chk(tag, "divisor", divisor, {m_dhi, m_dlo});
        chk(tag, "line_ctl", {8'h0, line_ctl}, {8'h0, m_lctl});
        chk(tag, "modem_ctl", {8'h0, modem_ctl}, {8'h0, m_mctl});
        chk(tag, "irq_en", {8'h0, irq_en}, {8'h0, m_ien});
        @(posedge clk);
        @(negedge clk);
        // one-cycle strobes
        chk("R3", "rx_pop idle", {15'h0, rx_pop}, 16'h0);
        chk("R4", "tx_push idle", {15'h0, tx_push}, 16'h0);
        chk("R7", "fifo_ctl_stb idle", {15'h0, fifo_ctl_stb}, 16'h0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rdata", {8'h0, rdata}, 16'h0);
        chk("R1", "strobes", {13'h0, rx_pop, tx_push, fifo_ctl_stb}, 16'h0);
        chk("R1", "divisor", divisor, 16'h0);
        chk("R1", "line_ctl", {8'h0, line_ctl}, 16'h0);
        chk("R1", "ctl", {modem_ctl, irq_en}, 16'h0);
        // R2 no chip select: writes and reads ignored
        do_op(1, 3'd3, 2'd3, 8'h80);
        do_op(1, 3'd7, 2'd3, 8'h5A);
        do_op(0, 3'd0, 2'd3, 8'h00);
        do_op(0, 3'd7, 2'd0, 8'h00);
        // R10 each select alone and both
        do_op(1, 3'd7, 2'd1, 8'hA5);
        do_op(0, 3'd7, 2'd2, 8'h00);
        // R9 every word length
        for (int wl = 0; wl < 4; wl++) begin
            do_op(1, 3'd3, 2'd0, 8'(wl));
            do_op(0, 3'd0, 2'd1, 8'h00);
        end
        // R6 divisor bank
        do_op(1, 3'd3, 2'd0, 8'h83);
        do_op(1, 3'd0, 2'd0, 8'h34);
        do_op(1, 3'd1, 2'd1, 8'h12);
        do_op(0, 3'd0, 2'd0, 8'h00);
        do_op(0, 3'd1, 2'd0, 8'h00);
        // R7 FCR write does not read back
        do_op(1, 3'd2, 2'd0, 8'hC7);
        do_op(0, 3'd2, 2'd0, 8'h00);
        do_op(1, 3'd3, 2'd0, 8'h03);
        // R8 status writes ignored
        do_op(1, 3'd5, 2'd0, 8'hFF);
        do_op(1, 3'd6, 2'd0, 8'hFF);
        for (int i = 0; i < 600; i++) begin
            logic [1:0] csm = ($urandom() % 8 == 0) ? 2'd3 : 2'($urandom() % 3);
            do_op(1'($urandom()), 3'($urandom()), csm, 8'($urandom()));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule